// File: doc/BRIEF.md
# Masked-ID Transaction Event Filter

This block watches one stream of bus handshakes and decides, for each of three event counters, whether the handshake counts and by how much. Each observed handshake carries an ID, a direction (read or write), a channel (address or data), a port number and a byte count. The counters themselves sit elsewhere. This block hands each one a one-cycle increment strobe and an increment amount.

An ID qualifies when the bits selected by a mask agree with a programmed value. The filter runs in one of two modes. In shared mode, every counter uses the same value/mask pair. In per-counter mode, each counter has its own pair plus a channel select and a port select. An independent byte-mode switch makes the filter add the beat's byte count instead of one per burst. A counter only takes part when it is programmed with one of the two filtered event codes.

Top module: `axid_evt_filter`

## Requirements
- R1: A handshake's ID matches a filter when `(id & mask) == (value & mask)`. A mask bit of 1 includes that ID bit in the comparison, and a mask bit of 0 ignores it.
- R2: Counter k can only be incremented when its event code is 0x41 or 0x42. Code 0x41 accepts only read handshakes (`obs_dir`=0) and code 0x42 accepts only write handshakes (`obs_dir`=1). Any other code never increments.
- R3: An observation counts only in a cycle where `obs_valid` and `obs_ready` are both high.
- R4: In shared mode (control bit0 = 0), all counters compare against the shared value/mask register. The per-counter value/mask and mux registers have no effect.
- R5: In per-counter mode (control bit0 = 1), each counter compares against its own value/mask register. The shared register has no effect.
- R6: In per-counter mode, mux bit0 picks the channel: 0 selects address handshakes (`obs_chan`=0) and 1 selects data beats (`obs_chan`=1). Handshakes on the other channel are ignored.
- R7: A handshake with `obs_port` not equal to 0 never matches. In per-counter mode, a counter whose mux port field is not 0 never matches.
- R8: With byte mode off (control bit1 = 0), every qualifying handshake adds 1. In shared mode, data beats are ignored.
- R9: With byte mode on, a qualifying data beat adds `obs_bytes`. In shared mode, address handshakes are ignored. In per-counter mode, a qualifying address handshake adds 1.
- R10: `inc_en` and `inc_amt` are registered and reflect the handshake of the previous cycle. A non-qualifying cycle gives strobe 0 and amount 0. Reset clears the outputs and every configuration register.
- R11: The register map uses word addresses. The control register is at 0. The shared filter is at 1, with the value in [15:0] and the mask in [31:16]. Event codes sit at 2+k for counter k = 0..2, in bits [7:0]. Per-counter value/mask registers sit at 5+k, in the same layout as the shared filter. Mux registers sit at 8+k, with the channel in bit0 and the port in bits [PORT_W:1]. Counter k drives `inc_en[k]` and `inc_amt[k*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| obs_valid | input | 1 | Observed VALID |
| obs_ready | input | 1 | Observed READY |
| obs_dir | input | 1 | 0 read, 1 write |
| obs_chan | input | 1 | 0 address channel, 1 data channel |
| obs_port | input | PORT_W | Observed port number |
| obs_id | input | ID_W | Observed transaction ID |
| obs_bytes | input | BYTES_W | Bytes moved by a data beat |
| inc_en | output | NCNT | Per-counter increment strobe |
| inc_amt | output | NCNT*BYTES_W | Per-counter increment amount |

## Verification
The bench builds the block with its defaults: three counters, 16-bit ID and mask fields, a 2-bit port, 8-bit byte counts and the per-counter variant present. Full-width masks and partial masks are both reachable. Ports 1 to 3 exercise the port rejection, and byte counts reach 64. Since every mode's registers exist side by side, the bench can program a shared pair and per-counter pairs with conflicting contents. It then switches modes to show that only the selected set steers the outcome.

// File: rtl/axf_pkg.sv
package axf_pkg;

   localparam int unsigned CFG_DW = 32;

   localparam logic [7:0] EVT_ID_RD = 8'h41;
   localparam logic [7:0] EVT_ID_WR = 8'h42;

   localparam int unsigned A_CTRL   = 0;
   localparam int unsigned A_SHARED = 1;
   localparam int unsigned A_EVT0   = 2;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;

   typedef enum logic {
      CH_ADDR = 1'b0,
      CH_DATA = 1'b1
   } chan_e;

endpackage

// File: rtl/axf_cfg_regs.sv
module axf_cfg_regs
   import axf_pkg::*;
#(
   parameter int unsigned NCNT       = 3,
   parameter int unsigned ID_W       = 16,
   parameter int unsigned PORT_W     = 2,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          PER_CNT_EN = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [ADDR_W-1:0]                cfg_addr,
   input  logic [CFG_DW-1:0]                cfg_wdata,
   output logic                             mode_pc,
   output logic                             byte_mode,
   output logic [ID_W-1:0]                  sh_val,
   output logic [ID_W-1:0]                  sh_mask,
   output logic [NCNT-1:0][7:0]             evt,
   output logic [NCNT-1:0][ID_W-1:0]        pc_val,
   output logic [NCNT-1:0][ID_W-1:0]        pc_mask,
   output logic [NCNT-1:0]                  pc_chan,
   output logic [NCNT-1:0][PORT_W-1:0]      pc_port
);

   localparam int unsigned PC_BASE  = A_EVT0 + NCNT;
   localparam int unsigned MUX_BASE = PC_BASE + NCNT;

   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata;

   logic mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         byte_mode <= 1'b0;
      end else if (cfg_we && cfg_addr == ADDR_W'(A_CTRL)) begin
         mode_q    <= cfg_wdata[0];
         byte_mode <= cfg_wdata[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_val  <= '0;
         sh_mask <= '0;
      end else if (cfg_we && cfg_addr == ADDR_W'(A_SHARED)) begin
         sh_val  <= cfg_wdata[ID_W-1:0];
         sh_mask <= cfg_wdata[16 +: ID_W];
      end
   end

   if (PER_CNT_EN) begin : g_mode_pc
      assign mode_pc = mode_q;
   end else begin : g_mode_shared_only
      assign mode_pc = 1'b0;
   end

   for (genvar k = 0; k < NCNT; k++) begin : g_ctr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            evt[k] <= '0;
         end else if (cfg_we && cfg_addr == ADDR_W'(A_EVT0 + k)) begin
            evt[k] <= cfg_wdata[7:0];
         end
      end

      if (PER_CNT_EN) begin : g_pc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_val[k]  <= '0;
               pc_mask[k] <= '0;
            end else if (cfg_we && cfg_addr == ADDR_W'(PC_BASE + k)) begin
               pc_val[k]  <= cfg_wdata[ID_W-1:0];
               pc_mask[k] <= cfg_wdata[16 +: ID_W];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_chan[k] <= 1'b0;
               pc_port[k] <= '0;
            end else if (cfg_we && cfg_addr == ADDR_W'(MUX_BASE + k)) begin
               pc_chan[k] <= cfg_wdata[0];
               pc_port[k] <= cfg_wdata[PORT_W:1];
            end
         end
      end else begin : g_no_pc
         assign pc_val[k]  = '0;
         assign pc_mask[k] = '0;
         assign pc_chan[k] = 1'b0;
         assign pc_port[k] = '0;
      end
   end

endmodule

// File: rtl/axf_ctr_match.sv
module axf_ctr_match
   import axf_pkg::*;
#(
   parameter int unsigned ID_W    = 16,
   parameter int unsigned PORT_W  = 2,
   parameter int unsigned BYTES_W = 8
) (
   input  logic               hs,
   input  logic               dir,
   input  logic               chan,
   input  logic [PORT_W-1:0]  port,
   input  logic [ID_W-1:0]    id,
   input  logic [BYTES_W-1:0] bytes,
   input  logic               mode_pc,
   input  logic               byte_mode,
   input  logic [7:0]         evt,
   input  logic [ID_W-1:0]    sh_val,
   input  logic [ID_W-1:0]    sh_mask,
   input  logic [ID_W-1:0]    pc_val,
   input  logic [ID_W-1:0]    pc_mask,
   input  logic               pc_chan,
   input  logic [PORT_W-1:0]  pc_port,
   output logic               qual,
   output logic [BYTES_W-1:0] amt
);

   logic            dir_ok;
   logic            id_ok;
   logic            chan_ok;
   logic            port_ok;
   logic [ID_W-1:0] sel_val;
   logic [ID_W-1:0] sel_mask;

   always_comb begin
      dir_ok = (evt == EVT_ID_RD && dir == DIR_RD) ||
               (evt == EVT_ID_WR && dir == DIR_WR);
   end

   always_comb begin
      sel_val  = mode_pc ? pc_val  : sh_val;
      sel_mask = mode_pc ? pc_mask : sh_mask;
      id_ok    = ((id ^ sel_val) & sel_mask) == '0;
   end

   always_comb begin
      if (mode_pc) begin
         chan_ok = (chan == pc_chan);
         port_ok = (port == '0) && (pc_port == '0);
         amt     = (byte_mode && chan == CH_DATA) ? bytes : BYTES_W'(1);
      end else begin
         chan_ok = byte_mode ? (chan == CH_DATA) : (chan == CH_ADDR);
         port_ok = (port == '0);
         amt     = byte_mode ? bytes : BYTES_W'(1);
      end
   end

   assign qual = hs && dir_ok && id_ok && chan_ok && port_ok;

endmodule

// File: rtl/axid_evt_filter.sv
module axid_evt_filter
   import axf_pkg::*;
#(
   parameter int unsigned NCNT       = 3,
   parameter int unsigned ID_W       = 16,
   parameter int unsigned PORT_W     = 2,
   parameter int unsigned BYTES_W    = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          PER_CNT_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [ADDR_W-1:0]         cfg_addr,
   input  logic [31:0]               cfg_wdata,
   input  logic                      obs_valid,
   input  logic                      obs_ready,
   input  logic                      obs_dir,
   input  logic                      obs_chan,
   input  logic [PORT_W-1:0]         obs_port,
   input  logic [ID_W-1:0]           obs_id,
   input  logic [BYTES_W-1:0]        obs_bytes,
   output logic [NCNT-1:0]           inc_en,
   output logic [NCNT*BYTES_W-1:0]   inc_amt
);

   localparam int unsigned AMT_W    = BYTES_W;
   localparam int unsigned N_REGS   = A_EVT0 + 3 * NCNT;

   if (ID_W < 1 || ID_W > 16) begin : g_bad_id_w
      $error("ID_W must lie in 1..16");
   end
   if (PORT_W < 1 || PORT_W > 8) begin : g_bad_port_w
      $error("PORT_W must lie in 1..8");
   end
   if (NCNT < 1) begin : g_bad_ncnt
      $error("NCNT must be at least 1");
   end
   if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end
   if (BYTES_W < 1) begin : g_bad_bytes_w
      $error("BYTES_W must be at least 1");
   end

   logic                        mode_pc_w;
   logic                        byte_mode_w;
   logic [ID_W-1:0]             sh_val_w;
   logic [ID_W-1:0]             sh_mask_w;
   logic [NCNT-1:0][7:0]        evt_w;
   logic [NCNT-1:0][ID_W-1:0]   pc_val_w;
   logic [NCNT-1:0][ID_W-1:0]   pc_mask_w;
   logic [NCNT-1:0]             pc_chan_w;
   logic [NCNT-1:0][PORT_W-1:0] pc_port_w;
   logic                        hs_w;

   assign hs_w = obs_valid & obs_ready;

   axf_cfg_regs #(
      .NCNT       (NCNT),
      .ID_W       (ID_W),
      .PORT_W     (PORT_W),
      .ADDR_W     (ADDR_W),
      .PER_CNT_EN (PER_CNT_EN)
   ) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .mode_pc   (mode_pc_w),
      .byte_mode (byte_mode_w),
      .sh_val    (sh_val_w),
      .sh_mask   (sh_mask_w),
      .evt       (evt_w),
      .pc_val    (pc_val_w),
      .pc_mask   (pc_mask_w),
      .pc_chan   (pc_chan_w),
      .pc_port   (pc_port_w)
   );

   for (genvar k = 0; k < NCNT; k++) begin : g_slice
      logic             qual_w;
      logic [AMT_W-1:0] amt_w;
      logic             en_q;
      logic [AMT_W-1:0] amt_q;

      axf_ctr_match #(
         .ID_W    (ID_W),
         .PORT_W  (PORT_W),
         .BYTES_W (BYTES_W)
      ) match_i (
         .hs        (hs_w),
         .dir       (obs_dir),
         .chan      (obs_chan),
         .port      (obs_port),
         .id        (obs_id),
         .bytes     (obs_bytes),
         .mode_pc   (mode_pc_w),
         .byte_mode (byte_mode_w),
         .evt       (evt_w[k]),
         .sh_val    (sh_val_w),
         .sh_mask   (sh_mask_w),
         .pc_val    (pc_val_w[k]),
         .pc_mask   (pc_mask_w[k]),
         .pc_chan   (pc_chan_w[k]),
         .pc_port   (pc_port_w[k]),
         .qual      (qual_w),
         .amt       (amt_w)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            amt_q <= '0;
         end else begin
            en_q  <= qual_w;
            amt_q <= qual_w ? amt_w : '0;
         end
      end

      assign inc_en[k]               = en_q;
      assign inc_amt[k*AMT_W +: AMT_W] = amt_q;
   end

endmodule

// File: rtl/axf_chk.sv
module axf_chk
   import axf_pkg::*;
#(
   parameter int unsigned NCNT    = 3,
   parameter int unsigned PORT_W  = 2,
   parameter int unsigned BYTES_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    obs_valid,
   input logic                    obs_ready,
   input logic                    obs_chan,
   input logic [PORT_W-1:0]       obs_port,
   input logic                    mode_pc,
   input logic                    byte_mode,
   input logic [NCNT-1:0][7:0]    evt,
   input logic [NCNT-1:0]         inc_en,
   input logic [NCNT*BYTES_W-1:0] inc_amt
);

   // R3
   no_handshake_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(obs_valid && obs_ready) |=> (inc_en == '0));

   // R7
   bad_port_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_valid && obs_ready && obs_port != '0) |=> (inc_en == '0));

   // R9
   shared_byte_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pc && byte_mode && obs_chan == CH_ADDR) |=> (inc_en == '0));

   for (genvar k = 0; k < NCNT; k++) begin : g_k
      // R2
      other_evt_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[k] != EVT_ID_RD && evt[k] != EVT_ID_WR) |=> !inc_en[k]);

      // R8
      burst_amt_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !byte_mode |=> (!inc_en[k] || inc_amt[k*BYTES_W +: BYTES_W] == BYTES_W'(1)));
   end

endmodule

bind axid_evt_filter axf_chk #(
   .NCNT    (NCNT),
   .PORT_W  (PORT_W),
   .BYTES_W (BYTES_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .obs_valid (obs_valid),
   .obs_ready (obs_ready),
   .obs_chan  (obs_chan),
   .obs_port  (obs_port),
   .mode_pc   (mode_pc_w),
   .byte_mode (byte_mode_w),
   .evt       (evt_w),
   .inc_en    (inc_en),
   .inc_amt   (inc_amt)
);

// File: tb/axid_evt_filter_tb_top.sv
`timescale 1ns/1ps
module axid_evt_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        obs_valid = 1'b0;
   logic        obs_ready = 1'b0;
   logic        obs_dir = 1'b0;
   logic        obs_chan = 1'b0;
   logic [1:0]  obs_port = '0;
   logic [15:0] obs_id = '0;
   logic [7:0]  obs_bytes = '0;
   logic [2:0]  inc_en;
   logic [23:0] inc_amt;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int         cyc;
      logic [2:0] en;
      logic [23:0] amt;
      string      tag;
   } item_t;

   item_t sb_q[$];
   item_t mon_it;

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   axid_evt_filter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .obs_valid (obs_valid),
      .obs_ready (obs_ready),
      .obs_dir   (obs_dir),
      .obs_chan  (obs_chan),
      .obs_port  (obs_port),
      .obs_id    (obs_id),
      .obs_bytes (obs_bytes),
      .inc_en    (inc_en),
      .inc_amt   (inc_amt)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: compares results one cycle after the driver pushed them
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
         mon_it = sb_q.pop_front();
         check(inc_en === mon_it.en, {mon_it.tag, " inc_en"}, 32'(inc_en), 32'(mon_it.en));
         check(inc_amt === mon_it.amt, {mon_it.tag, " inc_amt"}, 32'(inc_amt), 32'(mon_it.amt));
      end
   end

   // R11 register writes
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      obs_valid = 1'b0;
      obs_ready = 1'b0;
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic obs(input logic v, input logic r, input logic d, input logic ch,
                      input logic [1:0] p, input logic [15:0] id, input logic [7:0] by,
                      input logic [2:0] een, input logic [23:0] eamt, input string tag);
      item_t it;
      @(negedge clk);
      obs_valid = v;
      obs_ready = r;
      obs_dir   = d;
      obs_chan  = ch;
      obs_port  = p;
      obs_id    = id;
      obs_bytes = by;
      it.cyc = cyc;
      it.en  = een;
      it.amt = eamt;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic drain();
      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(inc_en === 3'b000, "R10 reset inc_en", 32'(inc_en), 0);
      check(inc_amt === 24'h0, "R10 reset inc_amt", 32'(inc_amt), 0);
      rst_n = 1'b1;

      // shared mode, burst counting
      wr(4'd0, 32'h0);
      wr(4'd1, {16'hFFFF, 16'h1234});
      wr(4'd2, 32'h41);
      wr(4'd3, 32'h42);
      wr(4'd4, 32'h41);

      obs(1,1,0,0,2'd0,16'h1234,8'd0, 3'b101, 24'h01_00_01, "R1 R8 full mask read hit");
      obs(0,0,0,0,2'd0,16'h0000,8'd0, 3'b000, 24'h0, "R10 idle after hit");
      obs(1,1,0,0,2'd0,16'h1235,8'd0, 3'b000, 24'h0, "R1 one bit differs");
      obs(1,1,1,0,2'd0,16'h1234,8'd0, 3'b010, 24'h00_01_00, "R2 write event only");
      obs(1,1,0,1,2'd0,16'h1234,8'd16,3'b000, 24'h0, "R8 data beat ignored in burst mode");
      obs(1,0,0,0,2'd0,16'h1234,8'd0, 3'b000, 24'h0, "R3 valid without ready");
      obs(0,1,0,0,2'd0,16'h1234,8'd0, 3'b000, 24'h0, "R3 ready without valid");
      obs(1,1,0,0,2'd1,16'h1234,8'd0, 3'b000, 24'h0, "R7 port 1 rejected");
      drain();

      // partial mask
      wr(4'd1, {16'h00F0, 16'h0030});
      obs(1,1,0,0,2'd0,16'hAB3C,8'd0, 3'b101, 24'h01_00_01, "R1 masked bits ignored");
      obs(1,1,0,0,2'd0,16'hAB4C,8'd0, 3'b000, 24'h0, "R1 unmasked nibble differs");
      drain();

      wr(4'd4, 32'h10);
      obs(1,1,0,0,2'd0,16'h0030,8'd0, 3'b001, 24'h00_00_01, "R2 other code never counts");
      drain();

      // shared byte mode
      wr(4'd0, 32'h2);
      obs(1,1,0,1,2'd0,16'hAB3C,8'd32,3'b001, 24'h00_00_20, "R9 shared data beat adds bytes");
      obs(1,1,0,0,2'd0,16'hAB3C,8'd32,3'b000, 24'h0, "R9 shared address ignored");
      obs(1,1,1,1,2'd2,16'hAB3C,8'd9, 3'b000, 24'h0, "R7 port 2 rejected in byte mode");
      drain();

      // per-counter mode, burst
      wr(4'd0, 32'h1);
      wr(4'd5, {16'hFFFF, 16'h0011});
      wr(4'd6, {16'hFFFF, 16'h0022});
      wr(4'd7, {16'h00FF, 16'h0033});
      wr(4'd8, 32'h0);
      wr(4'd9, 32'h1);
      wr(4'd10, 32'h2);
      wr(4'd4, 32'h41);

      obs(1,1,0,0,2'd0,16'h0011,8'd0, 3'b001, 24'h00_00_01, "R5 own filter counter 1");
      obs(1,1,1,1,2'd0,16'h0022,8'd5, 3'b010, 24'h00_01_00, "R6 data channel selected");
      obs(1,1,1,0,2'd0,16'h0022,8'd0, 3'b000, 24'h0, "R6 address ignored on data select");
      obs(1,1,0,0,2'd0,16'h0033,8'd0, 3'b000, 24'h0, "R7 mux port field nonzero");
      obs(1,1,0,0,2'd0,16'h0030,8'd0, 3'b000, 24'h0, "R5 shared pair unused");
      drain();

      wr(4'd10, 32'h0);
      obs(1,1,0,0,2'd0,16'h1133,8'd0, 3'b100, 24'h01_00_00, "R5 counter 3 own mask");
      drain();

      // per-counter mode, bytes
      wr(4'd0, 32'h3);
      obs(1,1,1,1,2'd0,16'h0022,8'd64,3'b010, 24'h00_40_00, "R9 per-counter data adds bytes");
      obs(1,1,0,0,2'd0,16'h0011,8'd64,3'b001, 24'h00_00_01, "R9 per-counter address adds one");
      drain();

      // back to shared: per-counter registers ignored
      wr(4'd0, 32'h0);
      obs(1,1,0,0,2'd0,16'h0030,8'd0, 3'b101, 24'h01_00_01, "R4 shared pair used again");
      obs(1,1,0,0,2'd0,16'h0011,8'd0, 3'b000, 24'h0, "R4 per-counter value unused");
      drain();

      // reset clears outputs and configuration
      obs(1,1,0,0,2'd0,16'h0030,8'd0, 3'b101, 24'h01_00_01, "R10 hit before reset");
      drain();
      obs(1,1,0,0,2'd0,16'h0030,8'd0, 3'b101, 24'h01_00_01, "R10 hit held into reset");
      @(posedge clk);
      #2 rst_n = 1'b0;
      sb_q.delete();
      @(negedge clk);
      check(inc_en === 3'b000, "R10 reset clears inc_en", 32'(inc_en), 0);
      check(inc_amt === 24'h0, "R10 reset clears inc_amt", 32'(inc_amt), 0);
      rst_n = 1'b1;
      obs(1,1,0,0,2'd0,16'h0030,8'd0, 3'b000, 24'h0, "R10 event codes cleared");
      obs(0,0,0,0,2'd0,16'h0000,8'd0, 3'b000, 24'h0, "R10 idle");
      drain();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule